// File: doc/BRIEF.md
# Display Cursor Register Bank with Frame-Aligned Commit

This block stores every setting a hardware cursor engine needs: the enable, drawing mode, 2x magnify and inverse-transparent clamp controls, the screen position, the hotspot offset, two colours, the size and a 40-bit surface base address. Software reaches it through a plain register port. A write strobe with a word address and data writes one register. A combinational read port returns the staged contents of any register.

Every write lands in a staged (pending) copy. The cursor engine sees only a live (active) copy. The live copy reloads from the staged copy on a frame-start pulse, and only while the software lock bit is clear. Software sets the lock, changes any group of registers and then clears the lock, so the whole group appears at one frame boundary. The 40-bit address is written in two halves. The upper half is held in a side register until the lower half arrives, so neither copy ever holds a mix of old and new halves.

This is a register interface, not a stream. It has no valid/ready handshake and no back-pressure. A write is accepted in the cycle its strobe is high, and the read data follows the read address within the same cycle.

Top module: `cursor_bank`

## Requirements
- R1: After reset, all staged and live fields are zero, the lock reads 0, and the live mode is monochrome (0).
- R2: A register write changes only the staged copy, so the live outputs stay unchanged until a commit.
- R3: When `frame_start` is high and the lock is 0, the live copy takes the staged values, visible one cycle later.
- R4: The lock is bit 0 of word 1. While it is 1, a `frame_start` pulse leaves the live copy unchanged.
- R5: Word 0 holds the control fields: enable at bit 0, mode at bits 2:1, magnify at bit 3 and clamp at bit 4. The mode codes are 0 monochrome, 1 colour with a 1-bit AND mask, 2 pre-multiplied alpha and 3 straight alpha.
- R6: Word 2 holds the position and word 3 the hotspot. In each, the horizontal value starts at bit 0 and the vertical value starts at bit 16.
- R7: Word 6 holds the size as value minus one: width-1 at bit 0 and height-1 at bit 16. A stored 0 means one pixel, and the stored values are driven out unchanged.
- R8: Word 7 holds address bits 39:32 in its bits 7:0. That write is held aside, and the staged address (and its readback) stays unchanged until word 8 is written. Word 8 then updates both halves together.
- R9: Word 8 holds address bits 31:0. Bits 11:0 of a write are ignored and always read back as zero (4 KB alignment).
- R10: When the live mode is monochrome, colour 1 drives 0x000000 and colour 2 drives 0xFFFFFF. In every other mode the live colour registers (words 4 and 5, 24-bit RGB) are driven out.
- R11: A write to any word above 8 is ignored, and a read of it returns zero.
- R12: `rd_data` shows the staged value of the word at `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Staged contents of the word at `rd_addr` |
| frame_start | input | 1 | Frame boundary pulse that requests a commit |
| cur_en | output | 1 | Live cursor enable |
| cur_mode | output | 2 | Live drawing mode |
| cur_mag | output | 1 | Live 2x magnify |
| cur_clamp | output | 1 | Live inverse-transparent clamp |
| cur_x | output | 13 | Live horizontal position |
| cur_y | output | 13 | Live vertical position |
| cur_hot_x | output | 6 | Live hotspot horizontal offset |
| cur_hot_y | output | 6 | Live hotspot vertical offset |
| cur_color1 | output | 24 | Live colour 1 (black in monochrome mode) |
| cur_color2 | output | 24 | Live colour 2 (white in monochrome mode) |
| cur_width_m1 | output | 7 | Live width minus one |
| cur_height_m1 | output | 7 | Live height minus one |
| cur_base | output | 40 | Live surface base address |

## Verification
The bound checker watches the commit rules on every cycle. The live copy moves only on an unlocked frame pulse, and then it equals the staged copy from one cycle earlier. A lone upper-address write never alters the staged address, and the monochrome colour override holds whenever the live mode is 0. The bench scenarios show what a property cannot express. These are the field positions and mode codes, the minus-one size encoding, the masking of the address alignment bits, the ignored unmapped words, and the full flow of setting the lock, writing several registers, clearing the lock and committing.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  parameter int DATA_W     = 32;
  parameter int REG_AW     = 4;
  parameter int COORD_W    = 13;
  parameter int HOT_W      = 6;
  parameter int SIZE_W     = 7;
  parameter int COLOR_W    = 24;
  parameter int BASE_W     = 40;
  parameter int ALIGN_BITS = 12;

  localparam int HI_W      = BASE_W - DATA_W;
  localparam int SECOND_LSB = 16;

  localparam logic [REG_AW-1:0] A_CTRL    = 4'd0;
  localparam logic [REG_AW-1:0] A_LOCK    = 4'd1;
  localparam logic [REG_AW-1:0] A_POS     = 4'd2;
  localparam logic [REG_AW-1:0] A_HOT     = 4'd3;
  localparam logic [REG_AW-1:0] A_COL1    = 4'd4;
  localparam logic [REG_AW-1:0] A_COL2    = 4'd5;
  localparam logic [REG_AW-1:0] A_SIZE    = 4'd6;
  localparam logic [REG_AW-1:0] A_ADDR_HI = 4'd7;
  localparam logic [REG_AW-1:0] A_ADDR_LO = 4'd8;

  typedef enum logic [1:0] {
    MODE_MONO     = 2'd0,
    MODE_ANDMASK  = 2'd1,
    MODE_PREMUL   = 2'd2,
    MODE_STRAIGHT = 2'd3
  } cur_mode_e;

  typedef struct packed {
    logic                en;
    cur_mode_e           mode;
    logic                mag;
    logic                clamp;
    logic [COORD_W-1:0]  x;
    logic [COORD_W-1:0]  y;
    logic [HOT_W-1:0]    hx;
    logic [HOT_W-1:0]    hy;
    logic [COLOR_W-1:0]  c1;
    logic [COLOR_W-1:0]  c2;
    logic [SIZE_W-1:0]   w;
    logic [SIZE_W-1:0]   h;
    logic [BASE_W-1:0]   base;
  } cur_regs_t;
endpackage

// File: rtl/cursor_stage.sv
module cursor_stage
  import cursor_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cur_regs_t         pend_o,
  output logic              lock_o
);
  cur_regs_t       pend_q;
  logic            lock_q;
  logic [HI_W-1:0] hi_hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      lock_q    <= 1'b0;
      hi_hold_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          pend_q.en    <= wr_data[0];
          pend_q.mode  <= cur_mode_e'(wr_data[2:1]);
          pend_q.mag   <= wr_data[3];
          pend_q.clamp <= wr_data[4];
        end
        A_LOCK: lock_q <= wr_data[0];
        A_POS: begin
          pend_q.x <= wr_data[COORD_W-1:0];
          pend_q.y <= wr_data[SECOND_LSB +: COORD_W];
        end
        A_HOT: begin
          pend_q.hx <= wr_data[HOT_W-1:0];
          pend_q.hy <= wr_data[SECOND_LSB +: HOT_W];
        end
        A_COL1:    pend_q.c1 <= wr_data[COLOR_W-1:0];
        A_COL2:    pend_q.c2 <= wr_data[COLOR_W-1:0];
        A_SIZE: begin
          pend_q.w <= wr_data[SIZE_W-1:0];
          pend_q.h <= wr_data[SECOND_LSB +: SIZE_W];
        end
        A_ADDR_HI: hi_hold_q <= wr_data[HI_W-1:0];
        A_ADDR_LO: pend_q.base <= {hi_hold_q, wr_data[DATA_W-1:ALIGN_BITS],
                                   {ALIGN_BITS{1'b0}}};
        default: ;
      endcase
    end
  end

  assign pend_o = pend_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/cursor_commit.sv
module cursor_commit
  import cursor_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_start,
  input  logic      lock,
  input  cur_regs_t pend,
  output cur_regs_t act_o
);
  cur_regs_t act_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    act_q <= '0;
    else if (frame_start && !lock) act_q <= pend;
  end

  assign act_o = act_q;
endmodule

// File: rtl/cursor_readback.sv
module cursor_readback
  import cursor_pkg::*;
(
  input  logic [REG_AW-1:0] rd_addr,
  input  cur_regs_t         pend,
  input  logic              lock,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[0]   = pend.en;
        rd_data[2:1] = pend.mode;
        rd_data[3]   = pend.mag;
        rd_data[4]   = pend.clamp;
      end
      A_LOCK: rd_data[0] = lock;
      A_POS: begin
        rd_data[COORD_W-1:0]          = pend.x;
        rd_data[SECOND_LSB +: COORD_W] = pend.y;
      end
      A_HOT: begin
        rd_data[HOT_W-1:0]          = pend.hx;
        rd_data[SECOND_LSB +: HOT_W] = pend.hy;
      end
      A_COL1: rd_data[COLOR_W-1:0] = pend.c1;
      A_COL2: rd_data[COLOR_W-1:0] = pend.c2;
      A_SIZE: begin
        rd_data[SIZE_W-1:0]          = pend.w;
        rd_data[SECOND_LSB +: SIZE_W] = pend.h;
      end
      A_ADDR_HI: rd_data[HI_W-1:0] = pend.base[BASE_W-1:DATA_W];
      A_ADDR_LO: rd_data = pend.base[DATA_W-1:0];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cursor_bank.sv
module cursor_bank
  import cursor_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [REG_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               frame_start,
  output logic               cur_en,
  output logic [1:0]         cur_mode,
  output logic               cur_mag,
  output logic               cur_clamp,
  output logic [COORD_W-1:0] cur_x,
  output logic [COORD_W-1:0] cur_y,
  output logic [HOT_W-1:0]   cur_hot_x,
  output logic [HOT_W-1:0]   cur_hot_y,
  output logic [COLOR_W-1:0] cur_color1,
  output logic [COLOR_W-1:0] cur_color2,
  output logic [SIZE_W-1:0]  cur_width_m1,
  output logic [SIZE_W-1:0]  cur_height_m1,
  output logic [BASE_W-1:0]  cur_base
);
  cur_regs_t pend_q;
  cur_regs_t act_q;
  logic      lock_q;

  cursor_stage u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pend_o  (pend_q),
    .lock_o  (lock_q)
  );

  cursor_commit u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .lock        (lock_q),
    .pend        (pend_q),
    .act_o       (act_q)
  );

  cursor_readback u_rd (
    .rd_addr (rd_addr),
    .pend    (pend_q),
    .lock    (lock_q),
    .rd_data (rd_data)
  );

  assign cur_en        = act_q.en;
  assign cur_mode      = act_q.mode;
  assign cur_mag       = act_q.mag;
  assign cur_clamp     = act_q.clamp;
  assign cur_x         = act_q.x;
  assign cur_y         = act_q.y;
  assign cur_hot_x     = act_q.hx;
  assign cur_hot_y     = act_q.hy;
  assign cur_width_m1  = act_q.w;
  assign cur_height_m1 = act_q.h;
  assign cur_base      = act_q.base;

  // Monochrome drawing uses a fixed black/white pair.
  always_comb begin
    if (act_q.mode == MODE_MONO) begin
      cur_color1 = '0;
      cur_color2 = '1;
    end else begin
      cur_color1 = act_q.c1;
      cur_color2 = act_q.c2;
    end
  end
endmodule

// File: rtl/cursor_bank_chk.sv
module cursor_bank_chk
  import cursor_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [REG_AW-1:0]  wr_addr,
  input logic               frame_start,
  input logic               lock_q,
  input cur_regs_t          pend,
  input cur_regs_t          act,
  input logic [1:0]         cur_mode,
  input logic [COLOR_W-1:0] cur_color1,
  input logic [COLOR_W-1:0] cur_color2
);
  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && lock_q) |=> (act == $past(act)));

  assert_commit_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !lock_q) |=> (act == $past(pend)));

  assert_live_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start) |=> (act == $past(act)));

  assert_hi_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ADDR_HI) |=> (pend.base == $past(pend.base)));

  assert_mono_colours_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'd0) |-> (cur_color1 == '0 && cur_color2 == '1));
endmodule

bind cursor_bank cursor_bank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .frame_start (frame_start),
  .lock_q      (lock_q),
  .pend        (pend_q),
  .act         (act_q),
  .cur_mode    (cur_mode),
  .cur_color1  (cur_color1),
  .cur_color2  (cur_color2)
);

// File: tb/tb_cursor_bank.sv
module tb_cursor_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        frame_start = 1'b0;
  logic        cur_en, cur_mag, cur_clamp;
  logic [1:0]  cur_mode;
  logic [12:0] cur_x, cur_y;
  logic [5:0]  cur_hot_x, cur_hot_y;
  logic [23:0] cur_color1, cur_color2;
  logic [6:0]  cur_width_m1, cur_height_m1;
  logic [39:0] cur_base;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cursor_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_start(frame_start), .cur_en(cur_en), .cur_mode(cur_mode),
    .cur_mag(cur_mag), .cur_clamp(cur_clamp), .cur_x(cur_x), .cur_y(cur_y),
    .cur_hot_x(cur_hot_x), .cur_hot_y(cur_hot_y), .cur_color1(cur_color1),
    .cur_color2(cur_color2), .cur_width_m1(cur_width_m1),
    .cur_height_m1(cur_height_m1), .cur_base(cur_base)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 en", cur_en, 0);
    check("R1 base", cur_base, 0);
    check("R1 mode", cur_mode, 0);
    check("R1 x", cur_x, 0);
    rd(4'd1, d); check("R1 lock", d, 0);
    check("R10 reset colour1", cur_color1, 24'h000000);
    check("R10 reset colour2", cur_color2, 24'hFFFFFF);
  endtask

  task automatic t_stage_commit();
    logic [31:0] d;
    wr(4'd0, 32'h17);
    wr(4'd2, {16'd200, 16'd100});
    wr(4'd3, {16'd9, 16'd33});
    check("R2 staged en not live", cur_en, 0);
    check("R2 staged x not live", cur_x, 0);
    rd(4'd0, d); check("R12 ctrl readback", d, 32'h17);
    rd(4'd2, d); check("R12 pos readback", d, {16'd200, 16'd100});
    commit();
    check("R3 en", cur_en, 1);
    check("R5 mode", cur_mode, 3);
    check("R5 clamp", cur_clamp, 1);
    check("R5 mag", cur_mag, 0);
    check("R6 x", cur_x, 100);
    check("R6 y", cur_y, 200);
    check("R6 hot x", cur_hot_x, 33);
    check("R6 hot y", cur_hot_y, 9);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(4'd1, 32'h1);
    rd(4'd1, d); check("R4 lock readback", d, 1);
    wr(4'd2, {16'd7, 16'd5});
    commit();
    check("R4 locked x held", cur_x, 100);
    check("R4 locked y held", cur_y, 200);
    wr(4'd1, 32'h0);
    commit();
    check("R3 unlocked x", cur_x, 5);
    check("R3 unlocked y", cur_y, 7);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    wr(4'd7, 32'hAB);
    rd(4'd7, d); check("R8 hi held readback", d, 0);
    commit();
    check("R8 hi alone not live", cur_base, 0);
    wr(4'd8, 32'h1234_5FFF);
    rd(4'd8, d); check("R9 low bits zero", d, 32'h1234_5000);
    rd(4'd7, d); check("R8 hi after low", d, 32'hAB);
    commit();
    check("R8 R9 full base", cur_base, 40'hAB_1234_5000);
  endtask

  task automatic t_size();
    wr(4'd6, {16'd31, 16'd0});
    commit();
    check("R7 width-1 zero", cur_width_m1, 0);
    check("R7 height-1", cur_height_m1, 31);
  endtask

  task automatic t_colour();
    logic [31:0] d;
    wr(4'd4, 32'h0011_2233);
    wr(4'd5, 32'h0044_5566);
    commit();
    check("R10 colour1 pass", cur_color1, 24'h112233);
    check("R10 colour2 pass", cur_color2, 24'h445566);
    wr(4'd0, 32'h09);
    commit();
    check("R5 mag", cur_mag, 1);
    check("R5 mono mode", cur_mode, 0);
    check("R10 mono colour1", cur_color1, 24'h000000);
    check("R10 mono colour2", cur_color2, 24'hFFFFFF);
    rd(4'd4, d); check("R10 colour1 reg kept", d, 32'h0011_2233);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(4'd15, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd15, d); check("R11 read zero", d, 0);
    rd(4'd2, d); check("R11 pos untouched", d, {16'd7, 16'd5});
    commit();
    check("R11 x untouched", cur_x, 5);
    check("R11 base untouched", cur_base, 40'hAB_1234_5000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage_commit();
    t_lock();
    t_addr();
    t_size();
    t_colour();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule